// File: doc/BRIEF.md
# Plasma Subframe Drive Sequencer

This block paces one frame of a binary-weighted subframe display. A frame-start strobe begins a frame. The frame is made of `NUM_SF` subframes, eight by default, run in index order. Every subframe goes through three phases in a fixed order:

1. A reset phase, during which the ramp enable is held high.
2. An address (write) phase, during which the write enable is high. A one-cycle row-scan start strobe marks the first cycle of this phase.
3. A sustain phase, during which pulses go out alternately on the X and Y sustain outputs.

Subframe k carries `FIRST_PULSES * 2^k` sustain pulses. With the defaults this gives pulse counts in the ratio 1:2:4:...:128, and 510 pulses in total for eight subframes.

All durations are parameters given in clock cycles. After the last subframe the block idles with every drive output low and waits for the next strobe. A strobe that arrives while a frame is still running raises a one-cycle overrun flag and restarts the frame at subframe 0.

The state machine has four states:
- `PH_IDLE` (code 0)
- `PH_RESET` (code 1)
- `PH_WRITE` (code 2)
- `PH_SUSTAIN` (code 3)

Its transitions are:
- START: from any state, on a strobe, go to `PH_RESET` at subframe 0.
- RAMP_DONE: `PH_RESET` to `PH_WRITE`.
- SCAN_DONE: `PH_WRITE` to `PH_SUSTAIN`.
- NEXT_SF: `PH_SUSTAIN` to `PH_RESET` with the subframe index plus one.
- FRAME_DONE: from `PH_SUSTAIN` of the last subframe to `PH_IDLE`.

Top module: `pdp_subframe_seq`

## Requirements
- R1: Each subframe visits reset, then write, then sustain. `phase` reports 0 for idle, 1 for reset, 2 for write and 3 for sustain.
- R2: The reset phase lasts `RESET_CYC` cycles and the write phase lasts `WRITE_CYC` cycles.
- R3: The sustain phase of subframe k holds `FIRST_PULSES << k` pulses of `PULSE_CYC` cycles each, with no gaps between them.
- R4: Sustain pulses alternate, with the first pulse of each subframe on `sus_x`. `sus_x` and `sus_y` are never high together.
- R5: `scan_start` is high for exactly one cycle, the first cycle of each write phase.
- R6: `subframe` counts 0 to `NUM_SF-1` through the frame, one step per completed sustain phase.
- R7: After the last subframe's sustain phase the block enters idle. In idle, `subframe` is 0 and every drive output is low.
- R8: A strobe seen in idle puts the block in reset of subframe 0 on the next cycle, with no overrun.
- R9: A strobe seen outside idle makes `overrun` high for the next cycle only, and restarts the frame at the reset phase of subframe 0.
- R10: After reset the block is idle with every output low.
- R11: `ramp_en` is high exactly in the reset phase, and `write_en` is high exactly in the write phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Frame-start strobe, one cycle |
| phase | output | 2 | Current phase code |
| subframe | output | $clog2(NUM_SF) | Current subframe index |
| ramp_en | output | 1 | Reset-ramp enable |
| write_en | output | 1 | Address-phase enable |
| scan_start | output | 1 | Row-scan start strobe |
| sus_x | output | 1 | X sustain pulse |
| sus_y | output | 1 | Y sustain pulse |
| overrun | output | 1 | Frame strobe arrived mid-frame |

## Verification
The main stimulus is a full frame from idle, sampled at chosen offsets.
- The samples fall on phase boundaries, pulse boundaries and subframe boundaries. This separates an off-by-one phase length from a wrong pulse count or a wrong X/Y order.
- A whole-frame count of X cycles, Y cycles and overlap cycles catches a doubling error or a missing subframe that point samples could miss.
- A strobe placed mid-frame, in the sustain phase of subframe 1, separates a correct restart from a simple continuation.
- A strobe in idle confirms that overrun is raised only for a true mid-frame strobe.

// File: rtl/pdp_seq_pkg.sv
package pdp_seq_pkg;
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_RESET   = 2'd1,
        PH_WRITE   = 2'd2,
        PH_SUSTAIN = 2'd3
    } phase_e;
endpackage

// File: rtl/pdp_phase_timer.sv
module pdp_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic [W-1:0] last,
    output logic         done,
    output logic         first
);
    logic [W-1:0] cnt_q;

    assign done  = (cnt_q == last);
    assign first = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clear)  cnt_q <= '0;
        else if (!done)  cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/pdp_sustain_alt.sv
module pdp_sustain_alt #(
    parameter int PULSE_CYC = 500,
    parameter int PW        = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          active,
    input  logic [PW-1:0] pulses_last,
    output logic          sus_x,
    output logic          sus_y,
    output logic          done
);
    localparam int CW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
    localparam logic [CW-1:0] CYC_LAST = CW'(PULSE_CYC - 1);

    logic [CW-1:0] cyc_q;
    logic [PW-1:0] pidx_q;
    logic          wrap;

    assign wrap  = (cyc_q == CYC_LAST);
    assign done  = active && wrap && (pidx_q == pulses_last);
    assign sus_x = active && !pidx_q[0];
    assign sus_y = active &&  pidx_q[0];

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cyc_q  <= '0;
            pidx_q <= '0;
        end else if (active) begin
            if (wrap) begin
                cyc_q <= '0;
                if (!done) pidx_q <= pidx_q + 1'b1;
            end else begin
                cyc_q <= cyc_q + 1'b1;
            end
        end
    end

    // Pulse boundary inside a subframe hands the drive to the other electrode
    assert_alt_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !clear && wrap && !done) |=> (sus_x == $past(sus_y)) && (sus_y == $past(sus_x)));
endmodule

// File: rtl/pdp_subframe_seq.sv
module pdp_subframe_seq
    import pdp_seq_pkg::*;
#(
    parameter int NUM_SF       = 8,
    parameter int RESET_CYC    = 5000,
    parameter int WRITE_CYC    = 175000,
    parameter int PULSE_CYC    = 500,
    parameter int FIRST_PULSES = 2,
    localparam int SF_W = (NUM_SF > 1) ? $clog2(NUM_SF) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_start,
    output logic [1:0]      phase,
    output logic [SF_W-1:0] subframe,
    output logic            ramp_en,
    output logic            write_en,
    output logic            scan_start,
    output logic            sus_x,
    output logic            sus_y,
    output logic            overrun
);
    localparam int TMAX = (RESET_CYC > WRITE_CYC) ? RESET_CYC : WRITE_CYC;
    localparam int TW   = $clog2(TMAX + 1);
    localparam int MAXP = FIRST_PULSES << (NUM_SF - 1);
    localparam int PW   = $clog2(MAXP + 1);
    localparam logic [SF_W-1:0] SF_LAST = SF_W'(NUM_SF - 1);

    phase_e          state_q, state_d;
    logic [SF_W-1:0] sf_q, sf_d;
    logic            overrun_q;
    logic            clear;
    logic [TW-1:0]   t_last;
    logic            t_done, t_first;
    logic [PW-1:0]   p_last;
    logic [31:0]     p_count;
    logic            s_done;
    logic            x_raw, y_raw;

    // Next state and subframe index
    always_comb begin
        state_d = state_q;
        sf_d    = sf_q;
        if (frame_start) begin
            state_d = PH_RESET;
            sf_d    = '0;
        end else begin
            unique case (state_q)
                PH_IDLE:    state_d = PH_IDLE;
                PH_RESET:   if (t_done) state_d = PH_WRITE;
                PH_WRITE:   if (t_done) state_d = PH_SUSTAIN;
                PH_SUSTAIN: if (s_done) begin
                    if (sf_q == SF_LAST) begin
                        state_d = PH_IDLE;
                        sf_d    = '0;
                    end else begin
                        state_d = PH_RESET;
                        sf_d    = sf_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign clear = frame_start || (state_d != state_q);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= PH_IDLE;
            sf_q      <= '0;
            overrun_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            sf_q      <= sf_d;
            overrun_q <= frame_start && (state_q != PH_IDLE);
        end
    end

    assign t_last  = (state_q == PH_WRITE) ? TW'(WRITE_CYC - 1) : TW'(RESET_CYC - 1);
    assign p_count = 32'(FIRST_PULSES) << sf_q;
    assign p_last  = PW'(p_count - 32'd1);

    pdp_phase_timer #(.W(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear),
        .last  (t_last),
        .done  (t_done),
        .first (t_first)
    );

    pdp_sustain_alt #(.PULSE_CYC(PULSE_CYC), .PW(PW)) u_sustain (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (clear),
        .active      (state_q == PH_SUSTAIN),
        .pulses_last (p_last),
        .sus_x       (x_raw),
        .sus_y       (y_raw),
        .done        (s_done)
    );

    // Outputs
    always_comb begin
        phase      = state_q;
        subframe   = sf_q;
        overrun    = overrun_q;
        ramp_en    = 1'b0;
        write_en   = 1'b0;
        scan_start = 1'b0;
        sus_x      = 1'b0;
        sus_y      = 1'b0;
        unique case (state_q)
            PH_IDLE:    ;
            PH_RESET:   ramp_en = 1'b1;
            PH_WRITE: begin
                write_en   = 1'b1;
                scan_start = t_first;
            end
            PH_SUSTAIN: begin
                sus_x = x_raw;
                sus_y = y_raw;
            end
        endcase
    end

    assert_reset_exit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_RESET && !frame_start) |=> (state_q == PH_RESET || state_q == PH_WRITE));
    assert_write_exit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_WRITE && !frame_start) |=> (state_q == PH_WRITE || state_q == PH_SUSTAIN));
    assert_drive_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sus_x, sus_y, ramp_en, write_en}));
    assert_scan_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        scan_start |=> !scan_start);
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_IDLE) |-> !(sus_x || sus_y || ramp_en || write_en || scan_start));
    assert_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (state_q == PH_RESET && sf_q == '0));
    assert_overrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && state_q != PH_IDLE) |=> overrun);
endmodule

// File: tb/test_pdp_subframe_seq.sv
`timescale 1ns/1ps
module test_pdp_subframe_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0;
    logic [1:0] phase;
    logic [2:0] subframe;
    logic       ramp_en, write_en, scan_start, sus_x, sus_y, overrun;

    int nchk = 0;
    int nfail = 0;
    int off = 0;
    bit done_flag = 0;

    always #5 clk = ~clk;

    pdp_subframe_seq #(
        .NUM_SF(8), .RESET_CYC(3), .WRITE_CYC(4), .PULSE_CYC(2), .FIRST_PULSES(2)
    ) i_pdp_subframe_seq (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .phase(phase), .subframe(subframe), .ramp_en(ramp_en), .write_en(write_en),
        .scan_start(scan_start), .sus_x(sus_x), .sus_y(sus_y), .overrun(overrun)
    );

    // offset, phase, subframe, sus_x, sus_y, scan_start
    localparam int NV = 20;
    localparam int VEC [NV][6] = '{
        '{0, 1, 0, 0, 0, 0}, '{2, 1, 0, 0, 0, 0}, '{3, 2, 0, 0, 0, 1}, '{4, 2, 0, 0, 0, 0},
        '{6, 2, 0, 0, 0, 0}, '{7, 3, 0, 1, 0, 0}, '{8, 3, 0, 1, 0, 0}, '{9, 3, 0, 0, 1, 0},
        '{10, 3, 0, 0, 1, 0}, '{11, 1, 1, 0, 0, 0}, '{14, 2, 1, 0, 0, 1}, '{18, 3, 1, 1, 0, 0},
        '{20, 3, 1, 0, 1, 0}, '{22, 3, 1, 1, 0, 0}, '{25, 3, 1, 0, 1, 0}, '{26, 1, 2, 0, 0, 0},
        '{564, 3, 7, 1, 0, 0}, '{1075, 3, 7, 0, 1, 0}, '{1076, 0, 0, 0, 0, 0}, '{1150, 0, 0, 0, 0, 0}
    };

    task automatic check(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s at offset %0d: actual %0d expected %0d", req, off, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        off++;
    endtask

    task automatic strobe();
        frame_start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        frame_start = 1'b0;
        off = 0;
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        nchk++;
        nfail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int vi, xc, yc, both;
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 phase", phase, 0);
        check("R10 drives", {ramp_en, write_en, scan_start, sus_x, sus_y, overrun}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 idle hold", phase, 0);

        // Vector walk over one full frame (R1 R2 R3 R4 R5 R6 R7 R8 R11)
        strobe();
        check("R8 no overrun from idle", overrun, 0);
        vi = 0; xc = 0; yc = 0; both = 0;
        for (int k = 0; k <= 1150; k++) begin
            if (sus_x && sus_y) both++;
            if (sus_x) xc++;
            if (sus_y) yc++;
            check("R11 ramp_en", ramp_en, (phase == 2'd1) ? 1 : 0);
            check("R11 write_en", write_en, (phase == 2'd2) ? 1 : 0);
            if (vi < NV && VEC[vi][0] == off) begin
                check("R1 phase", phase, VEC[vi][1]);
                check("R6 subframe", subframe, VEC[vi][2]);
                check("R4 sus_x", sus_x, VEC[vi][3]);
                check("R4 sus_y", sus_y, VEC[vi][4]);
                check("R5 scan_start", scan_start, VEC[vi][5]);
                vi++;
            end
            if (k < 1150) step();
        end
        check("R3 x cycles per frame", xc, 510);
        check("R3 y cycles per frame", yc, 510);
        check("R4 overlap cycles", both, 0);
        check("R7 idle drives", {sus_x, sus_y, ramp_en, write_en}, 0);

        // R9: strobe mid-frame
        strobe();
        while (off < 20) step();
        check("R9 before restart", subframe, 1);
        strobe();
        check("R9 overrun flag", overrun, 1);
        check("R9 restart phase", phase, 1);
        check("R9 restart subframe", subframe, 0);
        step();
        check("R9 overrun one cycle", overrun, 0);
        step(); step();
        check("R2 write after restart", phase, 2);
        check("R5 scan after restart", scan_start, 1);

        // R8: strobe in idle after a completed frame
        while (off < 1100) step();
        check("R7 idle reached", phase, 0);
        strobe();
        check("R8 idle strobe no overrun", overrun, 0);
        check("R8 reset entered", phase, 1);
        finish_run();
    end
endmodule